// File: doc/BRIEF.md
# Indexed Load/Store Address Generator

This block turns the operand fields of a single load or store into the byte address that goes to memory. In the same step it produces the new value for the base register. It handles four indexing modes: offset before access, offset before access with base update, offset after access, and program-counter-relative. The offset is either a 12-bit unsigned immediate or a register value shifted logically left or right by 0 to 31 places. A separate select chooses whether the offset is added or subtracted.

The inputs are registered once, so every result appears one clock after the request. Alongside the address, the block produces three things:
- a byte-lane enable mask, little-endian, for the memory port;
- an alignment-error flag for word accesses;
- a load-data path that places a returned byte in the low byte of the result and clears the upper bits.

Top module: `ldst_addr_gen`

## Requirements
- R1: Mode 0 (pre-index): the address is base plus or minus offset, and `wb_en` stays 0.
- R2: Mode 1 (pre-index with update): the address is base plus or minus offset, `wb_en` is 1 and `wb_value` equals the address.
- R3: Mode 2 (post-index): the address equals the base, `wb_en` is 1 and `wb_value` is base plus or minus offset.
- R4: When `use_reg_offs`=1, the offset is `offs_reg` shifted logically. It is shifted right when `shift_right`=1 and left otherwise, by `shift_amt`. An amount of 0 passes the value unchanged. `offs_sub`=1 subtracts the offset; `offs_sub`=0 adds it.
- R5: When `use_reg_offs`=0, the offset is `imm_offs` zero-extended to 32 bits.
- R6: Mode 3 (PC-relative): the address is `pc_val`+8 plus or minus the zero-extended immediate, so the reach is 4095 bytes either way. `use_reg_offs` and the shift fields are ignored, and `wb_en` is 0.
- R7: A word access (`is_byte`=0) whose address has bits [1:0] not equal to 0 sets `align_err` and forces `wb_en` to 0. A byte access never sets `align_err`.
- R8: `lane_mask` bit i enables bits [8i+7:8i]. A byte access enables only lane address[1:0]. A word access enables all four lanes.
- R9: `load_data` returns the whole `mem_rdata` word for a word access. For a byte access it returns the selected lane in bits [7:0], with bits [31:8] zero.
- R10: The results of a request appear one cycle after `req_valid` is sampled high, with `out_valid`=1. A cycle with no request gives `out_valid`=0, `wb_en`=0 and `align_err`=0. Reset clears all three.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| addr_mode | input | 2 | 0 pre, 1 pre with update, 2 post, 3 PC-relative |
| base_val | input | 32 | Base register value |
| pc_val | input | 32 | Address of the current operation |
| offs_reg | input | 32 | Offset register value |
| imm_offs | input | 12 | Unsigned immediate offset |
| use_reg_offs | input | 1 | 1 selects the shifted register offset |
| offs_sub | input | 1 | 1 subtracts the offset |
| shift_right | input | 1 | 1 shifts right, 0 shifts left (logical) |
| shift_amt | input | 5 | Shift distance |
| is_byte | input | 1 | 1 for a byte access, 0 for a word |
| mem_rdata | input | 32 | Word returned by memory for the current result |
| out_valid | output | 1 | Results valid |
| eff_addr | output | 32 | Access address |
| wb_value | output | 32 | New base register value |
| wb_en | output | 1 | Base register update enable |
| lane_mask | output | 4 | Byte-lane enables |
| align_err | output | 1 | Misaligned word access |
| load_data | output | 32 | Lane-aligned load result |

## Verification
The bench sweeps the four modes against three operand sets. Each set is crossed with immediate versus register offset, add versus subtract, both shift directions, five shift distances and both access sizes.
- The operand sets differ in base alignment, in whether the sum wraps past 2^32, and in whether the immediate sits at its 4095 limit.
- Zero and full-width shift distances show that a zero shift leaves the offset unchanged, and where bits fall off each end.
- Pairing post-index with pre-index separates the address from the update value.
- The misaligned base shows that alignment is judged on the address actually used, which is the base for post-index.
- A recognisable load word checks that each lane is steered to the low byte.

// File: rtl/agu_pkg.sv
// Shared types for the load/store address generator.
package agu_pkg;
    typedef enum logic [1:0] {
        AM_PRE    = 2'd0,
        AM_PRE_WB = 2'd1,
        AM_POST   = 2'd2,
        AM_PC_REL = 2'd3
    } addr_mode_e;
endpackage

// File: rtl/agu_offset_shifter.sv
// Logical shifter for the register offset.
// Assumes a shift amount narrower than log2 of the data width plus one.
module agu_offset_shifter #(
    parameter int DW = 32,
    parameter int SW = 5
) (
    input  logic [DW-1:0] din,
    input  logic [SW-1:0] amt,
    input  logic          right,
    output logic [DW-1:0] dout
);
    // Shift left or right with zero fill; an amount of 0 leaves the value as is.
    always_comb begin
        dout = right ? (din >> amt) : (din << amt);
    end
endmodule

// File: rtl/agu_addr_sum.sv
// Forms the access address and the base update value from one adder.
// Assumes the offset has already been selected and zero-extended.
module agu_addr_sum
    import agu_pkg::*;
#(
    parameter int AW       = 32,
    parameter int PC_AHEAD = 8
) (
    input  addr_mode_e    mode,
    input  logic [AW-1:0] base,
    input  logic [AW-1:0] pc,
    input  logic [AW-1:0] offset,
    input  logic          sub,
    output logic [AW-1:0] addr,
    output logic [AW-1:0] upd,
    output logic          upd_req
);
    logic [AW-1:0] src;
    logic [AW-1:0] moved;

    // Choose the operand being indexed: the pipelined PC or the base.
    always_comb begin
        src = (mode == AM_PC_REL) ? (pc + AW'(PC_AHEAD)) : base;
    end

    // Apply the offset in the selected direction.
    always_comb begin
        moved = sub ? (src - offset) : (src + offset);
    end

    // Pick the address/update pair for the mode.
    always_comb begin
        addr    = (mode == AM_POST) ? src : moved;
        upd     = moved;
        upd_req = (mode == AM_PRE_WB) || (mode == AM_POST);
    end
endmodule

// File: rtl/agu_lane_steer.sv
// Byte-lane enables and the alignment check for one access.
// Assumes little-endian lanes: lane i holds bits [8i+7:8i].
module agu_lane_steer #(
    parameter int LANES = 4,
    parameter int LB    = $clog2(LANES)
) (
    input  logic             byte_acc,
    input  logic [LB-1:0]    addr_lo,
    output logic [LANES-1:0] mask,
    output logic             misalign
);
    // One lane for a byte, all lanes for a word.
    always_comb begin
        mask = byte_acc ? (LANES'(1) << addr_lo) : {LANES{1'b1}};
    end

    // A word access must start on a lane-0 boundary.
    always_comb begin
        misalign = !byte_acc && (addr_lo != '0);
    end
endmodule

// File: rtl/agu_load_align.sv
// Moves the addressed byte of a returned word to the low byte, zero-filled.
// Assumes the lane and size come from the registered request.
module agu_load_align #(
    parameter int DW    = 32,
    parameter int LANES = DW / 8,
    parameter int LB    = $clog2(LANES)
) (
    input  logic          byte_acc,
    input  logic [LB-1:0] lane,
    input  logic [DW-1:0] rdata,
    output logic [DW-1:0] dout
);
    logic [7:0] lane_byte [LANES];

    // Split the word into its lanes.
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign lane_byte[g] = rdata[8*g +: 8];
    end

    // Word passes through; a byte is zero-extended from its lane.
    always_comb begin
        dout = byte_acc ? {{(DW-8){1'b0}}, lane_byte[lane]} : rdata;
    end
endmodule

// File: rtl/ldst_addr_gen.sv
// Load/store address generator: one registered stage producing the access
// address, the base update, the lane enables and the alignment flag.
// Assumes byte addressing and little-endian lanes.
module ldst_addr_gen
    import agu_pkg::*;
#(
    parameter int AW       = 32,
    parameter int IMM_W    = 12,
    parameter int SH_W     = 5,
    parameter int PC_AHEAD = 8,
    localparam int LANES   = AW / 8,
    localparam int LB      = $clog2(LANES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic [1:0]       addr_mode,
    input  logic [AW-1:0]    base_val,
    input  logic [AW-1:0]    pc_val,
    input  logic [AW-1:0]    offs_reg,
    input  logic [IMM_W-1:0] imm_offs,
    input  logic             use_reg_offs,
    input  logic             offs_sub,
    input  logic             shift_right,
    input  logic [SH_W-1:0]  shift_amt,
    input  logic             is_byte,
    input  logic [AW-1:0]    mem_rdata,
    output logic             out_valid,
    output logic [AW-1:0]    eff_addr,
    output logic [AW-1:0]    wb_value,
    output logic             wb_en,
    output logic [LANES-1:0] lane_mask,
    output logic             align_err,
    output logic [AW-1:0]    load_data
);
    addr_mode_e       mode;
    logic [AW-1:0]    shifted;
    logic [AW-1:0]    offset;
    logic [AW-1:0]    addr_c;
    logic [AW-1:0]    upd_c;
    logic             upd_req_c;
    logic [LANES-1:0] mask_c;
    logic             mis_c;
    logic             byte_q;
    logic [LB-1:0]    lane_q;

    assign mode = addr_mode_e'(addr_mode);

    agu_offset_shifter #(.DW(AW), .SW(SH_W)) u_shift (
        .din   (offs_reg),
        .amt   (shift_amt),
        .right (shift_right),
        .dout  (shifted)
    );

    // Register offset only outside PC-relative mode, else the immediate.
    always_comb begin
        if (use_reg_offs && (mode != AM_PC_REL)) begin
            offset = shifted;
        end else begin
            offset = {{(AW-IMM_W){1'b0}}, imm_offs};
        end
    end

    agu_addr_sum #(.AW(AW), .PC_AHEAD(PC_AHEAD)) u_sum (
        .mode    (mode),
        .base    (base_val),
        .pc      (pc_val),
        .offset  (offset),
        .sub     (offs_sub),
        .addr    (addr_c),
        .upd     (upd_c),
        .upd_req (upd_req_c)
    );

    agu_lane_steer #(.LANES(LANES), .LB(LB)) u_lane (
        .byte_acc (is_byte),
        .addr_lo  (addr_c[LB-1:0]),
        .mask     (mask_c),
        .misalign (mis_c)
    );

    // Result register; flags are qualified by the request and cleared on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            wb_en     <= 1'b0;
            align_err <= 1'b0;
            eff_addr  <= '0;
            wb_value  <= '0;
            lane_mask <= '0;
            byte_q    <= 1'b0;
            lane_q    <= '0;
        end else begin
            out_valid <= req_valid;
            wb_en     <= req_valid && upd_req_c && !mis_c;
            align_err <= req_valid && mis_c;
            eff_addr  <= addr_c;
            wb_value  <= upd_c;
            lane_mask <= mask_c;
            byte_q    <= is_byte;
            lane_q    <= addr_c[LB-1:0];
        end
    end

    agu_load_align #(.DW(AW), .LANES(LANES), .LB(LB)) u_load (
        .byte_acc (byte_q),
        .lane     (lane_q),
        .rdata    (mem_rdata),
        .dout     (load_data)
    );
endmodule

// File: rtl/ldst_addr_gen_checker.sv
// Temporal checks on the address generator ports, bound to every instance.
module ldst_addr_gen_checker #(
    parameter int AW    = 32,
    parameter int LANES = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic [1:0]       addr_mode,
    input logic [AW-1:0]    base_val,
    input logic             out_valid,
    input logic [AW-1:0]    eff_addr,
    input logic             wb_en,
    input logic [LANES-1:0] lane_mask,
    input logic             align_err
);
    // An update is only ever requested alongside a valid result.
    assert_upd_needs_valid_R10: assert property (@(posedge clk) disable iff (!rst_n)
        wb_en |-> out_valid);

    // The result follows the request by exactly one cycle.
    assert_one_cycle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (out_valid == $past(req_valid)));

    // A misaligned word never updates the base.
    assert_err_blocks_upd_R7: assert property (@(posedge clk) disable iff (!rst_n)
        align_err |-> !wb_en);

    // Lanes are either a single byte or the full word.
    assert_lane_shape_R8: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> ($onehot(lane_mask) || (lane_mask == {LANES{1'b1}})));

    // Post-index accesses the unmodified base.
    assert_post_uses_base_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && addr_mode == 2'd2) |=> (eff_addr == $past(base_val)));

    // PC-relative never updates a register.
    assert_pcrel_no_upd_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && addr_mode == 2'd3) |=> !wb_en);
endmodule

bind ldst_addr_gen ldst_addr_gen_checker #(.AW(AW), .LANES(LANES)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .addr_mode (addr_mode),
    .base_val  (base_val),
    .out_valid (out_valid),
    .eff_addr  (eff_addr),
    .wb_en     (wb_en),
    .lane_mask (lane_mask),
    .align_err (align_err)
);

// File: tb/ldst_addr_gen_tb_top.sv
`timescale 1ns/1ps
module ldst_addr_gen_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [1:0]  addr_mode = '0;
    logic [31:0] base_val = '0, pc_val = '0, offs_reg = '0, mem_rdata = '0;
    logic [11:0] imm_offs = '0;
    logic        use_reg_offs = 1'b0, offs_sub = 1'b0, shift_right = 1'b0, is_byte = 1'b0;
    logic [4:0]  shift_amt = '0;
    logic        out_valid, wb_en, align_err;
    logic [31:0] eff_addr, wb_value, load_data;
    logic [3:0]  lane_mask;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2 clk = ~clk;

    ldst_addr_gen dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .addr_mode(addr_mode),
        .base_val(base_val), .pc_val(pc_val), .offs_reg(offs_reg), .imm_offs(imm_offs),
        .use_reg_offs(use_reg_offs), .offs_sub(offs_sub), .shift_right(shift_right),
        .shift_amt(shift_amt), .is_byte(is_byte), .mem_rdata(mem_rdata),
        .out_valid(out_valid), .eff_addr(eff_addr), .wb_value(wb_value), .wb_en(wb_en),
        .lane_mask(lane_mask), .align_err(align_err), .load_data(load_data)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] amt_of(input int i);
        case (i)
            0: return 32'd0;
            1: return 32'd1;
            2: return 32'd2;
            3: return 32'd5;
            default: return 32'd31;
        endcase
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] bases [3] = '{32'h0000_1000, 32'h0000_2002, 32'hFFFF_FFFC};
        logic [31:0] regs  [3] = '{32'h0000_0040, 32'h8000_0001, 32'h0000_0003};
        logic [11:0] imms  [3] = '{12'h010, 12'hFFF, 12'h007};
        logic [31:0] pcs   [3] = '{32'h0000_0400, 32'h0000_0F00, 32'h0000_0010};
        repeat (3) @(negedge clk);
        // Reset state, R10
        chk("R10 reset out_valid", {31'b0, out_valid}, 32'd0);
        chk("R10 reset wb_en", {31'b0, wb_en}, 32'd0);
        chk("R10 reset align_err", {31'b0, align_err}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R10 idle out_valid", {31'b0, out_valid}, 32'd0);
        for (int md = 0; md < 4; md++)
        for (int ur = 0; ur < 2; ur++)
        for (int sb = 0; sb < 2; sb++)
        for (int rt = 0; rt < 2; rt++)
        for (int ai = 0; ai < 5; ai++)
        for (int by = 0; by < 2; by++)
        for (int s = 0; s < 3; s++) begin
            logic [31:0] off, src, mv, ea, wbv, msk, ld, amt;
            logic err, wbe;
            amt = amt_of(ai);
            req_valid = 1'b1; addr_mode = md[1:0];
            base_val = bases[s]; offs_reg = regs[s]; imm_offs = imms[s]; pc_val = pcs[s];
            use_reg_offs = ur[0]; offs_sub = sb[0]; shift_right = rt[0];
            shift_amt = amt[4:0]; is_byte = by[0];
            // expected values from the requirements
            if (md == 3 || ur == 0) off = {20'd0, imms[s]};
            else if (rt == 1) off = regs[s] >> amt;
            else off = regs[s] << amt;
            src = (md == 3) ? pcs[s] + 32'd8 : bases[s];
            mv  = sb ? src - off : src + off;
            ea  = (md == 2) ? src : mv;
            err = (by == 0) && (ea[1:0] != 2'd0);
            wbe = (md == 1 || md == 2) && !err;
            wbv = mv;
            msk = by ? (32'd1 << ea[1:0]) : 32'hF;
            @(negedge clk);
            mem_rdata = 32'hA1B2_C3D4;
            ld = by ? ((32'hA1B2_C3D4 >> (8 * ea[1:0])) & 32'hFF) : 32'hA1B2_C3D4;
            #0.1;
            chk("R10 out_valid", {31'b0, out_valid}, 32'd1);
            if (md == 0) chk("R1 pre address", eff_addr, ea);
            else if (md == 1) chk("R2 pre-update address", eff_addr, ea);
            else if (md == 2) chk("R3 post address", eff_addr, ea);
            else chk("R6 pc-relative address", eff_addr, ea);
            if (ur == 1 && md != 3) chk("R4 shifted offset update", wb_value, wbv);
            else if (md != 3) chk("R5 immediate offset update", wb_value, wbv);
            if (md == 1) chk("R2 update value", wb_value, ea);
            chk("R7 align_err", {31'b0, align_err}, {31'b0, err});
            if (md == 3) chk("R6 no update", {31'b0, wb_en}, 32'd0);
            else chk("R1 R2 R3 R7 wb_en", {31'b0, wb_en}, {31'b0, wbe});
            chk("R8 lane_mask", {28'b0, lane_mask}, msk);
            chk("R9 load_data", load_data, ld);
        end
        req_valid = 1'b0;
        @(negedge clk);
        chk("R10 no request out_valid", {31'b0, out_valid}, 32'd0);
        chk("R10 no request wb_en", {31'b0, wb_en}, 32'd0);
        chk("R10 no request align_err", {31'b0, align_err}, 32'd0);
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule